// File: doc/BRIEF.md
# Authenticated Configuration Stream Loader

The loader takes a configuration stream as 32-bit words over a valid/ready handshake and turns it into the contents of a small bank of configuration cells. A header word says whether the payload is encrypted. Encrypted words are XORed with a keystream that is derived from a stored key. In the same cycle, a keyed 64-bit MAC takes in each word exactly as it arrived. Payload goes into a staging bank first. The configuration cells only change after the 64-bit MAC that trails the stream has been compared with the MAC computed on chip.

If the two MACs agree, the staged words are copied into the configuration cells in one cycle and a start-up pulse is issued. If they differ, every configuration cell is cleared and the loader holds an error state. A malformed stream is also rejected and clears every cell. A malformed stream is one with a wrong sync word, an oversized length, or a plain header while forced decryption is on. The key is loaded once through a write port, and no output can observe it. The forced-decrypt setting is sticky until reset.

Top module: `cfg_auth_loader`

## Requirements
- R1: After reset, `error`, `loaded` and `startup` are low, and every configuration cell reads zero.
- R2: A stream is made of the following words, in order:
  - the sync word 0xAA995566;
  - a header word, where bit 0 = 1 means encrypted;
  - a length word N;
  - N payload words;
  - the MAC high word, then the MAC low word.
  
  `s_ready` is low during the cycle in which `startup` is high.
- R3: For an encrypted stream, payload word i is stored as received XOR s_i. Here s_0 = key[63:32] XOR key[31:0], with s_0 = 1 if that value is zero, and s_{i+1} = (s_i >> 1) XOR (s_i[0] ? 0x80200003 : 0). A plain stream stores words as received.
- R4: The MAC m starts at 0 when a header is accepted. Every received payload word w updates it as m = rotl(m XOR {32'b0,w} XOR key, 13) + 0x9E3779B97F4A7C15. The result is compared with the appended 64 bits.
- R5: On a MAC match, the following happen:
  - cells 0..N-1 take the payload;
  - cells N..DEPTH-1 read zero;
  - `startup` is high for exactly one cycle;
  - `loaded` goes high.
- R6: No configuration cell changes while a stream is still arriving. Cells change only at commit or on entry to error.
- R7: On a MAC mismatch, `error` goes high, every configuration cell reads zero, and no start-up pulse occurs.
- R8: A length above DEPTH causes an error as soon as the length word is accepted, and the rest of the stream is dropped. N = 0 and N = DEPTH are both accepted.
- R9: A first word that is not the sync word leads to error.
- R10: A pulse on `force_dec_set` sets forced decryption until reset. With it set, a header with bit 0 = 0 leads to error, while encrypted streams still load.
- R11: Only the first key write after reset takes effect, and later writes are ignored.
- R12: In error, words are accepted and dropped. Error is left only by a sync word that arrives after an `err_clear` pulse; a complete valid stream sent before the clear loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Loader accepts a word this cycle |
| key_we | input | 1 | Key write strobe (first one only) |
| key_wdata | input | 64 | Key value |
| force_dec_set | input | 1 | Pulse to set sticky forced decryption |
| err_clear | input | 1 | Arms exit from the error state |
| cfg_addr | input | AW | Configuration cell read address |
| cfg_data | output | 32 | Configuration cell contents |
| startup | output | 1 | One-cycle start-up pulse after commit |
| loaded | output | 1 | A stream has been committed |
| error | output | 1 | Loader is in the error state |

## Verification
The bench targets lengths at the edges: zero, exactly DEPTH, and DEPTH+1. A loader with an off-by-one length check would reject a full bank or accept an oversized one. It reads a cell mid-stream to catch a loader that writes cells before the MAC is checked. After a corrupted MAC, it confirms that earlier committed data is gone rather than left in place. It tries a second key write, after which a loader that overwrote the key would fail its next MAC. It sends a clean stream while in error without a clear, which a loader that leaves error too eagerly would load. It also sends a plain stream under forced decryption, which must not load.

// File: rtl/cfg_auth_pkg.sv
`timescale 1ns/1ps
package cfg_auth_pkg;

    localparam int          WORD_W    = 32;
    localparam int          MAC_W     = 64;
    localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
    localparam logic [31:0] KS_TAPS   = 32'h8020_0003;
    localparam logic [63:0] MAC_ADD   = 64'h9E37_79B9_7F4A_7C15;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HEADER,
        ST_LENGTH,
        ST_PAYLOAD,
        ST_MAC,
        ST_COMMIT,
        ST_RUN,
        ST_ERROR
    } ldr_state_e;

    function automatic logic [WORD_W-1:0] ks_seed(input logic [MAC_W-1:0] k);
        logic [WORD_W-1:0] s;
        s = k[63:32] ^ k[31:0];
        return (s == '0) ? 32'h1 : s;
    endfunction

    function automatic logic [WORD_W-1:0] ks_next(input logic [WORD_W-1:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? KS_TAPS : 32'h0);
    endfunction

    function automatic logic [MAC_W-1:0] mac_step(input logic [MAC_W-1:0] m,
                                                   input logic [WORD_W-1:0] w,
                                                   input logic [MAC_W-1:0] k);
        logic [MAC_W-1:0] x;
        x = m ^ {32'h0, w} ^ k;
        return {x[50:0], x[63:51]} + MAC_ADD;
    endfunction

endpackage

// File: rtl/cfg_auth_keystore.sv
`timescale 1ns/1ps
module cfg_auth_keystore
    import cfg_auth_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [MAC_W-1:0] key_wdata,
    input  logic             force_set,
    output logic [MAC_W-1:0] key_o,
    output logic             force_o
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_o    <= '0;
            locked_q <= 1'b0;
            force_o  <= 1'b0;
        end else begin
            if (key_we && !locked_q) begin
                key_o    <= key_wdata;
                locked_q <= 1'b1;
            end
            if (force_set) begin
                force_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_auth_crypt.sv
`timescale 1ns/1ps
module cfg_auth_crypt
    import cfg_auth_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic [WORD_W-1:0] word_in,
    input  logic [MAC_W-1:0]  key,
    output logic [WORD_W-1:0] ks,
    output logic [MAC_W-1:0]  mac
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ks  <= '0;
            mac <= '0;
        end else if (init) begin
            ks  <= ks_seed(key);
            mac <= '0;
        end else if (step) begin
            ks  <= ks_next(ks);
            mac <= mac_step(mac, word_in, key);
        end
    end
endmodule

// File: rtl/cfg_auth_store.sv
`timescale 1ns/1ps
module cfg_auth_store
    import cfg_auth_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              commit,
    input  logic              wipe,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] stage_q [DEPTH];
    logic [WORD_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || wipe) begin
                stage_q[i] <= '0;
                cells_q[i] <= '0;
            end else if (commit) begin
                cells_q[i] <= stage_q[i];
                stage_q[i] <= '0;
            end else if (wr_en && wr_idx == AW'(i)) begin
                stage_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? cells_q[rd_addr] : '0;
endmodule

// File: rtl/cfg_auth_loader.sv
`timescale 1ns/1ps
module cfg_auth_loader
    import cfg_auth_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    input  logic              key_we,
    input  logic [MAC_W-1:0]  key_wdata,
    input  logic              force_dec_set,
    input  logic              err_clear,
    input  logic [AW-1:0]     cfg_addr,
    output logic [WORD_W-1:0] cfg_data,
    output logic              startup,
    output logic              loaded,
    output logic              error
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              enc;
        logic [CW-1:0]     len;
        logic [CW-1:0]     idx;
        logic              mac_ph;
        logic [WORD_W-1:0] mac_hi;
        logic              armed;
    } ctx_t;

    ldr_state_e        state_q, state_d;
    ctx_t              ctx_q, ctx_d;
    logic [MAC_W-1:0]  key_q;
    logic              force_q;
    logic [WORD_W-1:0] ks;
    logic [MAC_W-1:0]  mac_cur;
    logic              accept, crypt_init, crypt_step, wr_en, commit, wipe;
    logic [WORD_W-1:0] wr_data;

    cfg_auth_keystore u_keys (
        .clk(clk), .rst(rst), .key_we(key_we), .key_wdata(key_wdata),
        .force_set(force_dec_set), .key_o(key_q), .force_o(force_q)
    );

    cfg_auth_crypt u_crypt (
        .clk(clk), .rst(rst), .init(crypt_init), .step(crypt_step),
        .word_in(s_data), .key(key_q), .ks(ks), .mac(mac_cur)
    );

    cfg_auth_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(ctx_q.idx[AW-1:0]),
        .wr_data(wr_data), .commit(commit), .wipe(wipe),
        .rd_addr(cfg_addr), .rd_data(cfg_data)
    );

    assign s_ready = (state_q != ST_IDLE) && (state_q != ST_COMMIT);
    assign accept  = s_valid && s_ready;
    assign wr_data = ctx_q.enc ? (s_data ^ ks) : s_data;
    assign startup = (state_q == ST_COMMIT);
    assign loaded  = (state_q == ST_RUN);
    assign error   = (state_q == ST_ERROR);
    assign wipe    = (state_d == ST_ERROR) && (state_q != ST_ERROR);

    always_comb begin
        state_d    = state_q;
        ctx_d      = ctx_q;
        crypt_init = 1'b0;
        crypt_step = 1'b0;
        wr_en      = 1'b0;
        commit     = 1'b0;
        if (state_q != ST_MAC) ctx_d.mac_ph = 1'b0;
        if (state_q != ST_ERROR)  ctx_d.armed = 1'b0;
        else if (err_clear)       ctx_d.armed = 1'b1;
        case (state_q)
            ST_IDLE: state_d = ST_SYNC;
            ST_SYNC, ST_RUN: begin
                if (accept) state_d = (s_data == SYNC_WORD) ? ST_HEADER : ST_ERROR;
            end
            ST_HEADER: begin
                if (accept) begin
                    ctx_d.enc  = s_data[0];
                    crypt_init = 1'b1;
                    state_d    = (force_q && !s_data[0]) ? ST_ERROR : ST_LENGTH;
                end
            end
            ST_LENGTH: begin
                if (accept) begin
                    ctx_d.len = CW'(s_data);
                    ctx_d.idx = '0;
                    if (s_data > 32'(DEPTH))  state_d = ST_ERROR;
                    else if (s_data == '0)    state_d = ST_MAC;
                    else                      state_d = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (accept) begin
                    wr_en      = 1'b1;
                    crypt_step = 1'b1;
                    ctx_d.idx  = ctx_q.idx + CW'(1);
                    if (ctx_q.idx == ctx_q.len - CW'(1)) state_d = ST_MAC;
                end
            end
            ST_MAC: begin
                if (accept) begin
                    if (!ctx_q.mac_ph) begin
                        ctx_d.mac_hi = s_data;
                        ctx_d.mac_ph = 1'b1;
                    end else begin
                        ctx_d.mac_ph = 1'b0;
                        state_d = ({ctx_q.mac_hi, s_data} == mac_cur) ? ST_COMMIT : ST_ERROR;
                    end
                end
            end
            ST_COMMIT: begin
                commit  = 1'b1;
                state_d = ST_RUN;
            end
            ST_ERROR: begin
                if (accept && ctx_q.armed && s_data == SYNC_WORD) state_d = ST_HEADER;
            end
            default: state_d = ST_ERROR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
        end else begin
            state_q <= state_d;
            ctx_q   <= ctx_d;
        end
    end
endmodule

// File: rtl/cfg_auth_loader_chk.sv
`timescale 1ns/1ps
module cfg_auth_loader_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          startup,
    input logic          loaded,
    input logic          error,
    input logic          s_ready,
    input logic [AW-1:0] cfg_addr,
    input logic [31:0]   cfg_data,
    input logic [63:0]   key,
    input logic          force_dec
);
    assert_ready_low_commit_R2: assert property (@(posedge clk) disable iff (rst)
        startup |-> !s_ready);

    assert_single_startup_R5: assert property (@(posedge clk) disable iff (rst)
        startup |=> !startup);

    assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({startup, loaded, error}));

    assert_cells_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_data) && $stable(cfg_addr)) |-> ($past(startup) || error));

    assert_wipe_on_error_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> (cfg_data == 32'h0));

    assert_force_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $past(force_dec) |-> force_dec);

    assert_key_locked_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(key) != 64'h0) |-> $stable(key));

    assert_drain_in_error_R12: assert property (@(posedge clk) disable iff (rst)
        error |-> s_ready);
endmodule

bind cfg_auth_loader cfg_auth_loader_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst(rst), .startup(startup), .loaded(loaded), .error(error),
    .s_ready(s_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .key(key_q), .force_dec(force_q)
);

// File: tb/test_cfg_auth_loader.sv
`timescale 1ns/1ps
module test_cfg_auth_loader;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [31:0] SYNC = 32'hAA99_5566;
    localparam logic [63:0] K1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] K2 = 64'hFEED_FACE_0BAD_F00D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_valid = 1'b0;
    logic [31:0]   s_data = '0;
    logic          s_ready;
    logic          key_we = 1'b0;
    logic [63:0]   key_wdata = '0;
    logic          force_dec_set = 1'b0;
    logic          err_clear = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_data;
    logic          startup, loaded, error;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    logic prev_err = 1'b0;
    int mon_got;
    int mon_exp;

    always #2.5 clk = ~clk;

    cfg_auth_loader #(.DEPTH(DEPTH)) i_cfg_auth_loader (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .key_we(key_we), .key_wdata(key_wdata), .force_dec_set(force_dec_set),
        .err_clear(err_clear), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .startup(startup), .loaded(loaded), .error(error)
    );

    function automatic logic [31:0] seed_of(input logic [63:0] k);
        logic [31:0] v;
        v = k[63:32] ^ k[31:0];
        if (v == 32'h0) v = 32'h1;
        return v;
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] v);
        return (v >> 1) ^ (v[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic logic [63:0] mac_upd(input logic [63:0] m, input logic [31:0] w,
                                            input logic [63:0] k);
        logic [63:0] t;
        t = m ^ {32'h0, w} ^ k;
        return ((t << 13) | (t >> 51)) + 64'h9E37_79B9_7F4A_7C15;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] base, input int i);
        return base + 32'(i) * 32'h1111_0001;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = w;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic rd_cfg(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = AW'(a);
        #1;
        chk(req, cfg_data, exp);
    endtask

    task automatic run_stream(input logic [31:0] sync_w, input logic enc, input int n,
                              input logic [31:0] base, input logic [63:0] k,
                              input logic bad_mac, input logic hold_chk,
                              input logic [31:0] hold_exp);
        logic [31:0] s;
        logic [63:0] m;
        logic [31:0] w;
        s = seed_of(k);
        m = 64'h0;
        send(sync_w);
        send({31'h0, enc});
        send(32'(n));
        for (int i = 0; i < n; i++) begin
            w = enc ? (pat(base, i) ^ s) : pat(base, i);
            m = mac_upd(m, w, k);
            s = adv(s);
            send(w);
        end
        if (hold_chk) rd_cfg(0, hold_exp, "R6 cell changed before MAC check");
        if (bad_mac) m = m ^ 64'h1;
        send(m[63:32]);
        send(m[31:0]);
        repeat (4) @(negedge clk);
    endtask

    task automatic outcome_seen(input string req);
        chk(req, 64'(exp_q.size()), 64'h0);
    endtask

    // Monitor: pops the expected outcome (1 = start-up, 2 = error) when one appears
    always @(negedge clk) begin
        if (rst) begin
            prev_err = 1'b0;
        end else begin
            mon_got = 0;
            if (startup) mon_got = 1;
            else if (error && !prev_err) mon_got = 2;
            prev_err = error;
            if (mon_got != 0) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R12 unexpected outcome actual=%0d expected=none", mon_got);
                end else begin
                    mon_exp = exp_q.pop_front();
                    chk((mon_exp == 1) ? "R5 outcome" : "R7 outcome", 64'(mon_got), 64'(mon_exp));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 error", 64'(error), 64'h0);
        chk("R1 loaded", 64'(loaded), 64'h0);
        chk("R1 startup", 64'(startup), 64'h0);
        rd_cfg(0, 32'h0, "R1 cell 0");
        rd_cfg(DEPTH - 1, 32'h0, "R1 last cell");

        // R11: first key write wins, second is ignored
        @(negedge clk); key_we = 1'b1; key_wdata = K1;
        @(negedge clk); key_wdata = K2;
        @(negedge clk); key_we = 1'b0;

        // R2 plain stream of three words
        exp_q.push_back(1);
        run_stream(SYNC, 1'b0, 3, 32'hA000_0010, K1, 1'b0, 1'b0, 32'h0);
        outcome_seen("R5 plain stream committed");
        chk("R5 loaded", 64'(loaded), 64'h1);
        for (int i = 0; i < 3; i++) rd_cfg(i, pat(32'hA000_0010, i), "R2 plain payload");
        rd_cfg(3, 32'h0, "R5 cell above N");

        // R3 encrypted stream, R6 hold while streaming, R11 key from first write
        exp_q.push_back(1);
        run_stream(SYNC, 1'b1, 4, 32'h5B00_0C07, K1, 1'b0, 1'b1, pat(32'hA000_0010, 0));
        outcome_seen("R11 encrypted stream under first key committed");
        for (int i = 0; i < 4; i++) rd_cfg(i, pat(32'h5B00_0C07, i), "R3 decrypted payload");

        // R4/R7 corrupted MAC wipes committed cells
        exp_q.push_back(2);
        run_stream(SYNC, 1'b1, 2, 32'h0F0F_0001, K1, 1'b1, 1'b0, 32'h0);
        outcome_seen("R4 bad MAC rejected");
        chk("R7 error level", 64'(error), 64'h1);
        chk("R7 loaded low", 64'(loaded), 64'h0);
        rd_cfg(0, 32'h0, "R7 cell 0 wiped");
        rd_cfg(3, 32'h0, "R7 cell 3 wiped");

        // R12: valid stream without a clear is dropped
        run_stream(SYNC, 1'b0, 1, 32'h7777_0000, K1, 1'b0, 1'b0, 32'h0);
        chk("R12 still in error", 64'(error), 64'h1);
        rd_cfg(0, 32'h0, "R12 no load before clear");

        // R12 clear then a full-depth stream (R8 boundary)
        pulse_clear();
        exp_q.push_back(1);
        run_stream(SYNC, 1'b1, DEPTH, 32'h3C00_0100, K1, 1'b0, 1'b0, 32'h0);
        outcome_seen("R12 load after clear");
        rd_cfg(0, pat(32'h3C00_0100, 0), "R8 full depth first cell");
        rd_cfg(DEPTH - 1, pat(32'h3C00_0100, DEPTH - 1), "R8 full depth last cell");

        // R8 oversized length
        exp_q.push_back(2);
        send(SYNC);
        send(32'h1);
        send(32'(DEPTH + 1));
        chk("R8 error right after length", 64'(error), 64'h1);
        for (int i = 0; i < DEPTH + 3; i++) send(pat(32'h4444_0000, i));
        repeat (4) @(negedge clk);
        outcome_seen("R8 oversized rejected");
        chk("R8 rest dropped", 64'(error), 64'h1);
        rd_cfg(DEPTH - 1, 32'h0, "R7 wipe on length error");

        // R8 zero-length stream
        pulse_clear();
        exp_q.push_back(1);
        run_stream(SYNC, 1'b0, 0, 32'h0, K1, 1'b0, 1'b0, 32'h0);
        outcome_seen("R8 zero length committed");
        chk("R8 loaded", 64'(loaded), 64'h1);

        // R9 wrong sync
        exp_q.push_back(2);
        run_stream(32'hAA99_5567, 1'b0, 1, 32'h1234_0000, K1, 1'b0, 1'b0, 32'h0);
        outcome_seen("R9 bad sync rejected");
        chk("R9 error", 64'(error), 64'h1);

        // R10 forced decryption
        pulse_clear();
        @(negedge clk); force_dec_set = 1'b1;
        @(negedge clk); force_dec_set = 1'b0;
        exp_q.push_back(2);
        run_stream(SYNC, 1'b0, 2, 32'h6600_0000, K1, 1'b0, 1'b0, 32'h0);
        outcome_seen("R10 plain header rejected");
        rd_cfg(0, 32'h0, "R10 nothing loaded");
        pulse_clear();
        exp_q.push_back(1);
        run_stream(SYNC, 1'b1, 2, 32'h6600_0000, K1, 1'b0, 1'b0, 32'h0);
        outcome_seen("R10 encrypted stream loads");
        rd_cfg(1, pat(32'h6600_0000, 1), "R10 decrypted word");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule